// File: doc/BRIEF.md
# Lane Coordinate Handoff Controller

This block sits between a streaming producer of lane coordinate words and a software consumer. After an enabled start pulse it collects a fixed number of coordinate words (40 by default) into an on-chip buffer, in the order they arrive. Once the buffer is full and the producer signals completion, it raises a ready flag for software. It then keeps the buffer frozen for as long as software needs it.

Software reads the buffer through a combinational read port. It claims the data by raising a busy line and gives it back by lowering that line again. This is a four-phase handshake. The ready flag stays high for the whole time software is busy, and it drops only after the busy line has returned low. The controller then goes back to idle and waits for the next start.

Top module: `lane_handoff_ctrl`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) forces the idle state and drives ready_o low. It also rewinds the write pointer, so the next collection writes its first word to entry 0.
- R2: A start pulse moves the block from idle to collecting only when en_i is high in the same cycle. A start with en_i low is ignored, and coordinates sent after it are not stored.
- R3: While collecting, each cycle with wr_valid_i high (and sw_busy_i low) stores wr_data_i at the entry the write pointer names, then advances the pointer by one. Entry k holds the (k+1)-th accepted word.
- R4: done_i has no effect until all DEPTH entries are written. This includes a done_i that arrives in the same cycle as the last write. With the buffer full, done_i makes ready_o high from the next cycle.
- R5: Valid coordinates that arrive while collecting but after DEPTH words are already stored are dropped. The stored contents do not change.
- R6: While sw_busy_i is high, no coordinate is accepted in any state, and the buffer contents read through the port stay unchanged.
- R7: ready_o stays high while software is busy. It goes low in the cycle after sw_busy_i returns low from the held state, and the block is idle one cycle later.
- R8: Coordinates that arrive while ready, held or releasing are dropped and leave the buffer contents unchanged.
- R9: rd_data_o is combinational: it equals the entry at rd_addr_i when rd_addr_i < DEPTH, and is zero for any higher address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Enable gating the start of a collection |
| start_i | input | 1 | Request to begin collecting |
| done_i | input | 1 | Producer indicates the collection may close |
| sw_busy_i | input | 1 | Software owns the buffer while high |
| wr_valid_i | input | 1 | Coordinate word strobe |
| wr_data_i | input | DATA_W | Coordinate word |
| rd_addr_i | input | ADDR_W | Read port entry index |
| rd_data_o | output | DATA_W | Entry at rd_addr_i, zero when out of range |
| ready_o | output | 1 | Buffer full and available to software |

## Verification
The interesting collisions are between the last buffer write and done_i in a single cycle, and between a coordinate strobe and sw_busy_i in a single cycle. The bench drives done_i in the same cycle as the 40th write and checks that ready_o stays low until a later done_i. It also drives a strobe together with sw_busy_i during collection and checks that the word never appears in the buffer. In both cases the verdict comes from ready_o timing and from a full readback of the buffer, compared against the queue of words the bench expected to be accepted.

// File: rtl/lane_handoff_ctrl.sv
module lane_handoff_ctrl #(
  parameter int DEPTH  = 40,
  parameter int DATA_W = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_i,
  input  logic              start_i,
  input  logic              done_i,
  input  logic              sw_busy_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              ready_o
);
  localparam int PTR_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] FULL = PTR_W'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_FILL, S_READY, S_HOLD, S_REL} state_t;

  state_t           state, state_nx;
  logic [PTR_W-1:0] ptr;
  logic [DATA_W-1:0] mem [DEPTH];
  logic             full, wr_en;

  assign full  = (ptr == FULL);
  assign wr_en = (state == S_FILL) && wr_valid_i && !sw_busy_i && !full;

  always_comb begin
    state_nx = state;
    case (state)
      S_IDLE:  if (en_i && start_i) state_nx = S_FILL;
      S_FILL:  if (full && done_i)  state_nx = S_READY;
      S_READY: if (sw_busy_i)       state_nx = S_HOLD;
      S_HOLD:  if (!sw_busy_i)      state_nx = S_REL;
      S_REL:                        state_nx = S_IDLE;
      default:                      state_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      ptr   <= '0;
    end else begin
      state <= state_nx;
      if (state == S_IDLE) ptr <= '0;
      else if (wr_en)      ptr <= ptr + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (wr_en) mem[ptr[ADDR_W-1:0]] <= wr_data_i;

  assign ready_o   = (state == S_READY) || (state == S_HOLD);
  assign rd_data_o = (32'(rd_addr_i) < DEPTH) ? mem[rd_addr_i] : '0;
endmodule

module lane_handoff_ctrl_chk #(
  parameter int DEPTH  = 40,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6,
  parameter int PTR_W  = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              en_i,
  input logic              start_i,
  input logic              done_i,
  input logic              sw_busy_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              ready_o,
  input logic [2:0]        st,
  input logic [PTR_W-1:0]  ptr
);
  localparam logic [2:0] IDLE = 3'd0, HOLD = 3'd3;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!ready_o && st == IDLE && ptr == '0)); // R1
  AST_START_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    (st == IDLE && !en_i) |=> (st == IDLE)); // R2
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (rst) 32'(ptr) <= DEPTH); // R5
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> ($past(done_i) && 32'($past(ptr)) == DEPTH)); // R4
  AST_FROZEN_WHILE_READY: assert property (@(posedge clk) disable iff (rst)
    (ready_o && $past(ready_o) && $stable(rd_addr_i)) |-> $stable(rd_data_o)); // R6
  AST_RELEASE_DROPS: assert property (@(posedge clk) disable iff (rst)
    (st == HOLD && !sw_busy_i) |=> (!ready_o ##1 st == IDLE)); // R7
  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (st == HOLD && sw_busy_i) |=> ready_o); // R7
endmodule

bind lane_handoff_ctrl lane_handoff_ctrl_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .en_i(en_i), .start_i(start_i), .done_i(done_i),
  .sw_busy_i(sw_busy_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
  .ready_o(ready_o), .st(state), .ptr(ptr)
);

// File: tb/lane_handoff_ctrl_tb.sv
module lane_handoff_ctrl_tb;
  localparam int CLK_P  = 10;
  localparam int DEPTH  = 40;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 6;

  logic clk = 0, rst = 1, en = 0, start = 0, done = 0, busy = 0, valid = 0;
  logic [DATA_W-1:0] wdata = '0;
  logic [ADDR_W-1:0] raddr = '0;
  logic [DATA_W-1:0] rdata;
  logic ready;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [DATA_W-1:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  lane_handoff_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .en_i(en), .start_i(start), .done_i(done),
    .sw_busy_i(busy), .wr_valid_i(valid), .wr_data_i(wdata),
    .rd_addr_i(raddr), .rd_data_o(rdata), .ready_o(ready)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // driver: one strobe; pushes to the scoreboard only if acceptance is expected
  task automatic send(input logic [DATA_W-1:0] d, input bit accept, input bit with_busy, input bit with_done);
    valid = 1; wdata = d; busy = with_busy; done = with_done;
    if (accept) exp_q.push_back(d);
    tick();
    valid = 0; busy = 0; done = 0;
  endtask

  // monitor: pops every expected word and compares the buffer through the read port
  task automatic readback(input string req);
    chk({req, " depth"}, exp_q.size(), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      raddr = ADDR_W'(i);
      #1;
      if (exp_q.size() > 0) chk(req, rdata, exp_q.pop_front());
    end
    raddr = ADDR_W'(45);
    #1;
    chk("R9 out of range", rdata, 0);
    raddr = '0;
  endtask

  task automatic fill(input logic [DATA_W-1:0] base);
    for (int i = 0; i < DEPTH; i++) send(base + DATA_W'(i), 1, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(); tick();
    rst = 0;
    chk("R1 ready after reset", ready, 0);

    // R2: start without enable is ignored; the following strobe must not be stored
    start = 1; tick(); start = 0;
    send(16'hDEAD, 0, 0, 0);
    chk("R2 no ready", ready, 0);

    en = 1; start = 1; tick(); start = 0;
    for (int i = 0; i < 20; i++) send(16'h1000 + DATA_W'(i), 1, 0, 0);
    done = 1; tick(); done = 0;
    chk("R4 early done ignored", ready, 0);
    send(16'hBAD0, 0, 1, 0);                    // R6 strobe with busy in fill
    for (int i = 20; i < DEPTH - 1; i++) send(16'h1000 + DATA_W'(i), 1, 0, 0);
    send(16'h1000 + DATA_W'(DEPTH - 1), 1, 0, 1); // R4 done with last write
    chk("R4 done with last write", ready, 0);
    send(16'hBAD1, 0, 0, 0);                    // R5 overflow strobe
    chk("R5 no ready on overflow", ready, 0);
    done = 1; tick(); done = 0;
    chk("R4 ready after done", ready, 1);
    send(16'hBAD2, 0, 0, 0);                    // R8 strobe in ready
    chk("R4 ready held", ready, 1);

    busy = 1; tick();
    chk("R7 ready while busy", ready, 1);
    valid = 1; wdata = 16'hBAD3; tick(); valid = 0; // R6/R8 strobe in hold
    tick();
    chk("R7 ready still busy", ready, 1);
    readback("R3 R5 R6 R8 contents");
    busy = 0; tick();
    chk("R7 ready falls", ready, 0);
    valid = 1; wdata = 16'hBAD4; tick(); valid = 0;   // R8 strobe in release/idle

    // second round: pointer restarts at entry 0
    start = 1; tick(); start = 0;
    fill(16'h2000);
    done = 1; tick(); done = 0;
    chk("R3 second round ready", ready, 1);
    readback("R3 second round");
    busy = 1; tick(); busy = 0; tick();
    chk("R7 released", ready, 0);
    tick();

    // R1: reset in the middle of a fill rewinds the pointer
    start = 1; tick(); start = 0;
    for (int i = 0; i < 10; i++) send(16'h3000 + DATA_W'(i), 0, 0, 0);
    rst = 1; tick(); rst = 0;
    chk("R1 ready after mid reset", ready, 0);
    start = 1; tick(); start = 0;
    fill(16'h4000);
    done = 1; tick(); done = 0;
    chk("R1 ready after refill", ready, 1);
    readback("R1 refill from entry 0");

    finish_run();
  end
endmodule